// File: doc/BRIEF.md
# Flash command sequence interpreter

This block is the write-command front end of a parallel NOR-style flash device, modelled over a small internal word array. It watches bus write cycles and recognises two kinds of program request. The first is the full unlocked program: two key writes, a set-up write, then the target write. The second is a shortened program that is available only after the device has been put into a bypass mode. A recognised program starts a timed internal operation. That operation can only clear bits, and the ready output stays low while it runs.

While the operation runs, every write is discarded. Reads then return a status word instead of array contents. Outside a program operation, reads return the stored word. A low level on the asynchronous reset cancels an operation at once. Reset also returns the array to the erased (all ones) state and the interpreter to plain read mode. Only the low byte of the write data and the low eleven address bits take part in command matching. The low `ARRAY_AW` address bits select the word.

Top module: `flash_cmd_engine`

## Requirements
- R1: While reset is low and after it is released, `ready` is 1 and `rd_data` is 0, and every word reads as all ones.
- R2: The sequence AAh at address 555h, 55h at 2AAh, A0h at 555h, then a write carrying a target address and data, starts a program. `ready` is low for exactly PROG_CYCLES cycles, starting the cycle after the target write. The target word is updated when `ready` returns high, and the held target is cleared at that point.
- R3: A write that does not match the next expected key write returns the interpreter to read mode. A later A0h plus target write then changes no word.
- R4: Programming stores the old word ANDed with the new data, so a 0 bit written with 1 stays 0.
- R5: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode. In bypass mode, A0h at any address followed by a target write programs that word. This repeats for any addresses in any order, returning to bypass mode after each operation.
- R6: In bypass mode, any write other than A0h or 90h changes nothing, and neither does 90h followed by a non-00h write. The mode stays in bypass either way.
- R7: In bypass mode, 90h then 00h at any addresses returns to read mode, after which A0h plus a target write programs nothing and the full unlocked sequence works again.
- R8: Every write while `ready` is low is discarded: it neither extends the operation nor advances command decoding.
- R9: A read (`bus_re` high) updates `rd_data` at the next clock edge. While `ready` is low the value has bit 7 equal to the inverse of bit 7 of the data being programmed, bit 6 equal to a toggle bit that is 0 on the first read of each operation and flips on every read, and all other bits 0. Otherwise the value is the word at the read address.
- R10: Reset low during a program operation forces `ready` high at once, leaves the word unprogrammed, and the interpreter accepts a new full sequence afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; cancels a running operation |
| bus_addr | input | ADDR_W | Word address for writes and reads |
| bus_wdata | input | DATA_W | Write data; low byte carries command codes |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe, one read per high cycle |
| rd_data | output | DATA_W | Registered read result (array word or status) |
| ready | output | 1 | 1 when idle, 0 while a program operation runs |

## Verification
The main function is driven by full unlocked sequences, bypass-mode short sequences across scattered addresses, and key sequences with one wrong address or data byte. Together these separate correct decoding from decoding that ignores addresses, that fails to reset on a mismatch, or that leaks bypass behaviour into read mode. Writes that repeat the unlock keys during a busy period show whether the interpreter truly freezes, and status reads at alternating points in the operation show whether the toggle bit starts from 0 and advances only on reads. Overwriting a programmed word with all ones tells a clearing-only store apart from a plain overwrite, and a reset in mid-operation tells a clean abort apart from a late commit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ     = 3'd0,
      ST_KEY1     = 3'd1,
      ST_KEY2     = 3'd2,
      ST_STD_TGT  = 3'd3,
      ST_BYP      = 3'd4,
      ST_BYP_TGT  = 3'd5,
      ST_BYP_QUIT = 3'd6,
      ST_BUSY     = 3'd7
   } fce_state_e;

   localparam int unsigned CMD_ADDR_W = 11;

   localparam logic [7:0] CODE_KEY1     = 8'hAA;
   localparam logic [7:0] CODE_KEY2     = 8'h55;
   localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
   localparam logic [7:0] CODE_BYP_IN   = 8'h20;
   localparam logic [7:0] CODE_BYP_OUT1 = 8'h90;
   localparam logic [7:0] CODE_BYP_OUT2 = 8'h00;

   localparam logic [CMD_ADDR_W-1:0] ADDR_KEY1 = 11'h555;
   localparam logic [CMD_ADDR_W-1:0] ADDR_KEY2 = 11'h2AA;

endpackage

// File: rtl/fce_decoder.sv
module fce_decoder
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ARRAY_AW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                op_done,
   output logic                busy,
   output logic                start_op,
   output logic [ARRAY_AW-1:0] tgt_addr,
   output logic [DATA_W-1:0]   tgt_data
);

   fce_state_e state_q, state_d;
   logic       ret_byp_q, ret_byp_d;

   logic [7:0]            code;
   logic [CMD_ADDR_W-1:0] cadr;
   logic                  at_key1, at_key2;

   assign code    = wr_data[7:0];
   assign cadr    = wr_addr[CMD_ADDR_W-1:0];
   assign at_key1 = (cadr == ADDR_KEY1);
   assign at_key2 = (cadr == ADDR_KEY2);

   always_comb begin
      state_d   = state_q;
      ret_byp_d = ret_byp_q;
      start_op  = 1'b0;
      unique case (state_q)
         ST_READ: begin
            if (wr_en) state_d = (at_key1 && code == CODE_KEY1) ? ST_KEY1 : ST_READ;
         end
         ST_KEY1: begin
            if (wr_en) state_d = (at_key2 && code == CODE_KEY2) ? ST_KEY2 : ST_READ;
         end
         ST_KEY2: begin
            if (wr_en) begin
               if (at_key1 && code == CODE_PROGRAM)     state_d = ST_STD_TGT;
               else if (at_key1 && code == CODE_BYP_IN) state_d = ST_BYP;
               else                                     state_d = ST_READ;
            end
         end
         ST_STD_TGT: begin
            if (wr_en) begin
               state_d   = ST_BUSY;
               start_op  = 1'b1;
               ret_byp_d = 1'b0;
            end
         end
         ST_BYP: begin
            if (wr_en) begin
               if (code == CODE_PROGRAM)       state_d = ST_BYP_TGT;
               else if (code == CODE_BYP_OUT1) state_d = ST_BYP_QUIT;
            end
         end
         ST_BYP_TGT: begin
            if (wr_en) begin
               state_d   = ST_BUSY;
               start_op  = 1'b1;
               ret_byp_d = 1'b1;
            end
         end
         ST_BYP_QUIT: begin
            if (wr_en) state_d = (code == CODE_BYP_OUT2) ? ST_READ : ST_BYP;
         end
         ST_BUSY: begin
            if (op_done) state_d = ret_byp_q ? ST_BYP : ST_READ;
         end
         default: state_d = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_READ;
         ret_byp_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         ret_byp_q <= ret_byp_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_addr <= '0;
         tgt_data <= '0;
      end else if (start_op) begin
         tgt_addr <= wr_addr[ARRAY_AW-1:0];
         tgt_data <= wr_data;
      end else if (op_done) begin
         tgt_addr <= '0;
         tgt_data <= '0;
      end
   end

   assign busy = (state_q == ST_BUSY);

endmodule

// File: rtl/fce_prog_timer.sv
module fce_prog_timer #(
   parameter int unsigned PROG_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_op,
   input  logic busy,
   output logic op_done
);

   localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

   generate
      if (PROG_CYCLES == 1) begin : g_single
         assign op_done = busy;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (start_op)             cnt_q <= LOAD;
            else if (busy && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
         end

         assign op_done = busy && (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/fce_array.sv
module fce_array #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ARRAY_AW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic [ARRAY_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ARRAY_AW-1:0] rd_addr,
   output logic [DATA_W-1:0]   rd_word
);

   localparam int unsigned DEPTH = 1 << ARRAY_AW;

   logic [DATA_W-1:0] words [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         logic [DATA_W-1:0] cell_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '1;
            else if (commit && wr_addr == ARRAY_AW'(w))
               cell_q <= cell_q & wr_data;
         end

         assign words[w] = cell_q;
      end
   endgenerate

   assign rd_word = words[rd_addr];

endmodule

// File: rtl/fce_read_port.sv
module fce_read_port #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              busy,
   input  logic              start_op,
   input  logic              tgt_bit7,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rd_data
);

   logic              toggle_q;
   logic [DATA_W-1:0] status_word;

   always_comb begin
      status_word    = '0;
      status_word[7] = ~tgt_bit7;
      status_word[6] = toggle_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         toggle_q <= 1'b0;
      end else begin
         if (start_op) toggle_q <= 1'b0;
         if (rd_en) begin
            if (busy) begin
               rd_data  <= status_word;
               toggle_q <= ~toggle_q;
            end else begin
               rd_data  <= array_word;
            end
         end
      end
   end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ARRAY_AW    = 5,
   parameter int unsigned PROG_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] rd_data,
   output logic              ready
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("flash_cmd_engine: DATA_W must be at least 8");
      end
      if (ADDR_W < 11) begin : g_bad_addr_w
         $error("flash_cmd_engine: ADDR_W must be at least 11");
      end
      if (ARRAY_AW < 1 || ARRAY_AW > ADDR_W || ARRAY_AW > 10) begin : g_bad_array_aw
         $error("flash_cmd_engine: ARRAY_AW must be 1..min(ADDR_W,10)");
      end
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("flash_cmd_engine: PROG_CYCLES must be at least 1");
      end
   endgenerate

   logic                busy;
   logic                start_op;
   logic                op_done;
   logic [ARRAY_AW-1:0] prog_addr;
   logic [DATA_W-1:0]   prog_data;
   logic [DATA_W-1:0]   arr_word;

   fce_decoder #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ARRAY_AW (ARRAY_AW)
   ) u_decoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we),
      .wr_addr  (bus_addr),
      .wr_data  (bus_wdata),
      .op_done  (op_done),
      .busy     (busy),
      .start_op (start_op),
      .tgt_addr (prog_addr),
      .tgt_data (prog_data)
   );

   fce_prog_timer #(
      .PROG_CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_op (start_op),
      .busy     (busy),
      .op_done  (op_done)
   );

   fce_array #(
      .DATA_W   (DATA_W),
      .ARRAY_AW (ARRAY_AW)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (op_done),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (bus_addr[ARRAY_AW-1:0]),
      .rd_word (arr_word)
   );

   fce_read_port #(
      .DATA_W (DATA_W)
   ) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (bus_re),
      .busy       (busy),
      .start_op   (start_op),
      .tgt_bit7   (prog_data[7]),
      .array_word (arr_word),
      .rd_data    (rd_data)
   );

   assign ready = ~busy;

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ARRAY_AW    = 5,
   parameter int unsigned PROG_CYCLES = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic                bus_re,
   input logic                ready,
   input logic [DATA_W-1:0]   rd_data,
   input logic [ARRAY_AW-1:0] lat_addr,
   input logic [DATA_W-1:0]   lat_data
);

   localparam int unsigned LEN_W = $clog2(PROG_CYCLES + 2);
   localparam logic [DATA_W-1:0] STATUS_PAD = ~(DATA_W'(8'hC0));

   logic [LEN_W-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len <= '0;
      else if (!ready) busy_len <= busy_len + LEN_W'(1);
      else             busy_len <= '0;
   end

   // R10: reset forces the idle indication
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_ready_R10: assert (ready)
            else $error("ready low while reset asserted");
      end
   end

   assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (busy_len < LEN_W'(PROG_CYCLES)))
      else $error("busy period longer than PROG_CYCLES");

   assert_busy_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (busy_len == LEN_W'(PROG_CYCLES)))
      else $error("busy period ended early");

   assert_latch_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (lat_addr == '0 && lat_data == '0))
      else $error("target still held after completion");

   assert_busy_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(bus_we))
      else $error("operation started without a write");

   assert_latch_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> ($stable(lat_data) && $stable(lat_addr)))
      else $error("held target changed during operation");

   assert_status_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !ready) |=> ((rd_data & STATUS_PAD) == '0))
      else $error("status word has stray bits");

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(
   .DATA_W      (DATA_W),
   .ARRAY_AW    (ARRAY_AW),
   .PROG_CYCLES (PROG_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_re   (bus_re),
   .ready    (ready),
   .rd_data  (rd_data),
   .lat_addr (prog_addr),
   .lat_data (prog_data)
);

// File: tb/flash_cmd_engine_bench.sv
`timescale 1ns/1ps
module flash_cmd_engine_bench;

   localparam int AW = 11;
   localparam int DW = 16;
   localparam int RW = 5;
   localparam int PC = 8;

   localparam int M_READ = 0, M_K1 = 1, M_K2 = 2, M_STD = 3,
                  M_BYP = 4, M_BTGT = 5, M_BQUIT = 6, M_BUSY = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] b_addr = '0;
   logic [DW-1:0] b_wdata = '0;
   logic          b_we = 1'b0;
   logic          b_re = 1'b0;
   logic [DW-1:0] rd_data;
   logic          ready;

   int tests = 0;
   int fails = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   flash_cmd_engine #(
      .ADDR_W (AW), .DATA_W (DW), .ARRAY_AW (RW), .PROG_CYCLES (PC)
   ) u_flash_cmd_engine (
      .clk (clk), .rst_n (rst_n), .bus_addr (b_addr), .bus_wdata (b_wdata),
      .bus_we (b_we), .bus_re (b_re), .rd_data (rd_data), .ready (ready)
   );

   // behavioural reference
   int            m_mode;
   int            m_left;
   bit            m_tog, m_ret;
   logic [DW-1:0] m_rd;
   logic [RW-1:0] m_paddr;
   logic [DW-1:0] m_pdata;
   logic [DW-1:0] m_mem [32];

   task automatic model_edge();
      logic [7:0] c;
      bit ak1, ak2;
      c   = b_wdata[7:0];
      ak1 = (b_addr == 11'h555);
      ak2 = (b_addr == 11'h2AA);
      if (b_re) begin
         if (m_mode == M_BUSY) begin
            m_rd = '0;
            m_rd[7] = ~m_pdata[7];
            m_rd[6] = m_tog;
            m_tog = ~m_tog;
         end else begin
            m_rd = m_mem[b_addr[RW-1:0]];
         end
      end
      if (m_mode == M_BUSY) begin
         if (m_left == 0) begin
            m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
            m_mode  = m_ret ? M_BYP : M_READ;
            m_paddr = '0;
            m_pdata = '0;
         end else begin
            m_left--;
         end
      end else if (b_we) begin
         case (m_mode)
            M_READ:  m_mode = (ak1 && c == 8'hAA) ? M_K1 : M_READ;
            M_K1:    m_mode = (ak2 && c == 8'h55) ? M_K2 : M_READ;
            M_K2:    m_mode = (ak1 && c == 8'hA0) ? M_STD :
                              (ak1 && c == 8'h20) ? M_BYP : M_READ;
            M_BYP:   m_mode = (c == 8'hA0) ? M_BTGT : (c == 8'h90) ? M_BQUIT : M_BYP;
            M_BQUIT: m_mode = (c == 8'h00) ? M_READ : M_BYP;
            default: begin
               m_ret   = (m_mode == M_BTGT);
               m_paddr = b_addr[RW-1:0];
               m_pdata = b_wdata;
               m_left  = PC - 1;
               m_tog   = 1'b0;
               m_mode  = M_BUSY;
            end
         endcase
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = M_READ; m_left = 0; m_tog = 0; m_ret = 0;
         m_rd = '0; m_paddr = '0; m_pdata = '0;
         for (int i = 0; i < 32; i++) m_mem[i] = '1;
      end else begin
         model_edge();
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmp_model();
      logic exp_rdy;
      exp_rdy = (m_mode != M_BUSY);
      tests++;
      if (ready !== exp_rdy || rd_data !== m_rd) begin
         fails++;
         $display("FAIL %s (clock compare): actual ready=%0b rd=%h expected ready=%0b rd=%h",
                  cur_req, ready, rd_data, exp_rdy, m_rd);
      end
   endtask

   task automatic step(input logic we, input logic re, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cmp_model();
      b_we = we; b_re = re; b_addr = a; b_wdata = d;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(1'b1, 1'b0, a, d);
   endtask

   task automatic idle();
      step(1'b0, 1'b0, '0, '0);
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      step(1'b0, 1'b1, a, '0);
      idle();
      chk(req, rd_data, exp);
   endtask

   task automatic wait_ready();
      int n = 0;
      do begin
         idle();
         n++;
      end while (!ready && n < 50);
   endtask

   task automatic std_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
      wr(11'h555, 16'h00A0);
      wr(a, d);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(4.0 * 100000);
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
   end

   initial begin
      int n;
      // R1 reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", {15'd0, ready}, 16'd1);
      chk("R1 rd_data in reset", rd_data, 16'h0000);
      rst_n = 1'b1;
      idle();
      chk("R1 ready after reset", {15'd0, ready}, 16'd1);
      rd_chk("R1 erased word", 11'd3, 16'hFFFF);

      // R2 full unlocked program and busy length
      cur_req = "R2";
      std_prog(11'd5, 16'h1234);
      n = 0;
      do begin
         idle();
         if (!ready) n++;
      end while (!ready && n < 50);
      chk("R2 busy cycles", 16'(n), 16'(PC));
      rd_chk("R2 programmed word", 11'd5, 16'h1234);

      // R9 status reads during busy
      cur_req = "R9";
      std_prog(11'd9, 16'h5A00);
      rd_chk("R9 status read 1", 11'd9, 16'h0080);
      rd_chk("R9 status read 2", 11'd9, 16'h00C0);
      rd_chk("R9 status read 3", 11'd9, 16'h0080);
      wait_ready();
      rd_chk("R9 array read after op", 11'd9, 16'h5A00);

      // R4 clear-only programming
      cur_req = "R4";
      std_prog(11'd5, 16'hFF0F);
      wait_ready();
      rd_chk("R4 AND result", 11'd5, 16'h1204);
      std_prog(11'd5, 16'hFFFF);
      wait_ready();
      rd_chk("R4 zero not restored", 11'd5, 16'h1204);

      // R3 mismatched key writes
      cur_req = "R3";
      wr(11'h555, 16'h00AA);
      wr(11'h2AB, 16'h0055);
      wr(11'h555, 16'h00A0);
      wr(11'd7, 16'h0000);
      idle();
      chk("R3 no op after bad address", {15'd0, ready}, 16'd1);
      rd_chk("R3 word untouched (addr)", 11'd7, 16'hFFFF);
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
      wr(11'h555, 16'h00A5);
      wr(11'd7, 16'h0000);
      idle();
      rd_chk("R3 word untouched (data)", 11'd7, 16'hFFFF);

      // R8 writes during busy discarded
      cur_req = "R8";
      std_prog(11'd12, 16'h00FF);
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
      wr(11'h555, 16'h00A0);
      wait_ready();
      wr(11'd13, 16'h0000);
      idle();
      chk("R8 no op from busy writes", {15'd0, ready}, 16'd1);
      rd_chk("R8 word 13 untouched", 11'd13, 16'hFFFF);
      rd_chk("R8 word 12 programmed", 11'd12, 16'h00FF);

      // R5 bypass programming, scattered addresses
      cur_req = "R5";
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
      wr(11'h555, 16'h0020);
      wr(11'd0, 16'h00A0);
      wr(11'd20, 16'h0F0F);
      wait_ready();
      wr(11'h123, 16'h00A0);
      wr(11'd3, 16'hAAAA);
      wait_ready();
      wr(11'd0, 16'h00A0);
      wr(11'd31, 16'h7777);
      wait_ready();
      rd_chk("R5 bypass word 20", 11'd20, 16'h0F0F);
      rd_chk("R5 bypass word 3", 11'd3, 16'hAAAA);
      rd_chk("R5 bypass word 31", 11'd31, 16'h7777);

      // R6 other writes ignored in bypass
      cur_req = "R6";
      wr(11'h2AA, 16'h0055);
      wr(11'h555, 16'h00AA);
      wr(11'd8, 16'h0000);
      wr(11'd0, 16'h00A0);
      wr(11'd4, 16'h1111);
      wait_ready();
      rd_chk("R6 still in bypass", 11'd4, 16'h1111);
      rd_chk("R6 stray write no effect", 11'd8, 16'hFFFF);
      wr(11'd0, 16'h0090);
      wr(11'd0, 16'h0012);
      wr(11'd0, 16'h00A0);
      wr(11'd6, 16'h2222);
      wait_ready();
      rd_chk("R6 half exit stays bypass", 11'd6, 16'h2222);

      // R7 bypass exit
      cur_req = "R7";
      wr(11'h3FF, 16'h0090);
      wr(11'h001, 16'h0000);
      wr(11'h555, 16'h00A0);
      wr(11'd10, 16'h0000);
      idle();
      chk("R7 short program rejected", {15'd0, ready}, 16'd1);
      rd_chk("R7 word 10 untouched", 11'd10, 16'hFFFF);
      std_prog(11'd10, 16'h0F00);
      wait_ready();
      rd_chk("R7 full sequence works", 11'd10, 16'h0F00);

      // R10 abort by reset
      cur_req = "R10";
      std_prog(11'd14, 16'h0000);
      idle();
      idle();
      chk("R10 busy before reset", {15'd0, ready}, 16'd0);
      @(negedge clk);
      cmp_model();
      rst_n = 1'b0;
      b_we = 1'b0; b_re = 1'b0;
      #1;
      chk("R10 ready forced high", {15'd0, ready}, 16'd1);
      repeat (2) idle();
      rst_n = 1'b1;
      idle();
      rd_chk("R10 aborted word erased", 11'd14, 16'hFFFF);
      std_prog(11'd14, 16'h00F0);
      wait_ready();
      rd_chk("R10 program after abort", 11'd14, 16'h00F0);

      idle();
      report();
      $finish;
   end

endmodule